// File: doc/BRIEF.md
# Prescaled 8/16-bit Timer

This block is a free-running up-counter for use as a small system timer. It counts either the full 16-bit word or only its low byte. It can advance on every core clock or on edges of an external input. The external input goes through a two-flop synchroniser and an edge detector. A hidden power-of-two prescaler can sit in front of the counter, or it can be bypassed. Software may change the bypass and the ratio while the counter runs. Any write that loads the count clears the hidden prescaler.

When the counter wraps to zero, a sticky overflow flag is set. Only a software write clears the flag, and the flag reaches the interrupt output only when the interrupt enable bit is set. A sleep input freezes counting, so no overflow can occur while the device sleeps. In 16-bit mode the two count bytes are accessed as a coherent pair:
- reading the low byte captures the high byte into a read buffer;
- writing the high byte only fills a write buffer, which is loaded into the count together with the next low-byte write.

Top module: `prescaled_timer`

## Requirements
- R1: The registers are at these addresses: 0 = count low byte, 1 = count high byte, 2 = control, 3 = status. After reset, every register reads 0x00 and `irq` is low.
- R2: The control register bits are: bit 7 = run enable, bit 6 = 8-bit mode, bit 5 = external source, bit 4 = falling-edge select, bit 3 = prescaler bypass, bits 2:0 = ratio code. While bit 7 is 0, the count and the prescaler both hold their values, and register writes still take effect.
- R3: With bit 3 set, the count advances by one on every qualified tick, and the prescaler stays at zero.
- R4: With bit 3 clear and ratio code n, the count advances once per 2^(n+1) qualified ticks, counted from a cleared prescaler (code 0 divides by 2, code 7 divides by 256).
- R5: A write to the low byte clears the prescaler. In 8-bit mode, a write to the high byte also clears it. Such writes leave the control register unchanged.
- R6: In 8-bit mode only the low byte counts. Its wrap from FFh to 00h sets the overflow flag, and the high byte keeps its value.
- R7: In 16-bit mode, only the wrap from FFFFh to 0000h sets the flag. A carry out of the low byte alone does not set it.
- R8: The status register holds the overflow flag in bit 0 and the interrupt enable in bit 1. The flag stays set until a status write with bit 0 = 0 clears it. `irq` is high exactly when both the flag and the enable are set.
- R9: In 16-bit mode, a read of the high byte returns the value captured at the most recent low-byte read.
- R10: In 16-bit mode, a high-byte write leaves the count unchanged. The written value is loaded into the high byte at the next low-byte write.
- R11: With bit 5 set, the count advances on edges of `ext_tick_in` only, and not on core clocks. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges.
- R12: While `sleep` is high, the count does not advance and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (captures the high byte on a low-byte read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_tick_in | input | 1 | Asynchronous external count source |
| sleep | input | 1 | Freezes counting while high |
| irq | output | 1 | Overflow interrupt, gated by the enable bit |

## Verification
The bench loads the count and then leaves the timer running for a known number of clock ticks at several prescaler ratios. A prescaler that ignores the ratio, or that is not cleared when the count is loaded, leaves a count that is off by one or more. Stopping the timer partway through a prescaler period checks that the prescaler keeps its residue: a design that reset the prescaler on disable would count one step fewer. Wrap tests set the count just below FFh and just below FFFFh. They catch a flag raised on a low-byte carry in 16-bit mode, and a high byte disturbed in 8-bit mode. The buffered high-byte tests read and write out of order, so a design that bypassed either buffer returns the newer byte where the older one is expected.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_BYTE_W      = 8;
    localparam int TMR_PRE_W       = 8;
    localparam int TMR_SYNC_STAGES = 2;

    typedef struct packed {
        logic       run;
        logic       narrow;
        logic       ext_src;
        logic       fall_edge;
        logic       bypass;
        logic [2:0] ratio;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        ADDR_CNT_LO = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_STAT   = 2'd3
    } tmr_addr_e;

    function automatic logic is_count_addr(input logic [1:0] a);
        return (a == ADDR_CNT_LO) || (a == ADDR_CNT_HI);
    endfunction

endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = TMR_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic use_ext,
    input  logic fall_edge,
    input  logic active,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic                   edge_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_comb begin
        if (fall_edge) edge_seen = prev_q & ~level;
        else           edge_seen = ~prev_q & level;
    end

    assign tick = active & (use_ext ? edge_seen : 1'b1);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = TMR_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bypass,
    input  logic [2:0]       ratio,
    input  logic             clr,
    output logic             inc,
    output logic [PRE_W-1:0] level
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i <= int'(ratio));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 pre_q <= '0;
        else if (clr || bypass)  pre_q <= '0;
        else if (tick)           pre_q <= pre_q + 1'b1;
    end

    assign inc   = bypass ? tick : (tick && ((pre_q & mask) == mask));
    assign level = pre_q;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    input  logic                narrow,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic                lo_re,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] count,
    output logic [BYTE_W-1:0]   hi_view,
    output logic                wrap
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] wbuf_q;
    logic [BYTE_W-1:0] rbuf_q;
    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;
    logic              loaded;

    assign lo_b   = cnt_q[BYTE_W-1:0];
    assign hi_b   = cnt_q[CNT_W-1:BYTE_W];
    assign loaded = lo_we || (narrow && hi_we);
    assign wrap   = inc && !loaded && (narrow ? (&lo_b) : (&cnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (lo_we) begin
            if (narrow) cnt_q[BYTE_W-1:0] <= wdata;
            else        cnt_q <= {wbuf_q, wdata};
        end else if (hi_we && narrow) begin
            cnt_q[CNT_W-1:BYTE_W] <= wdata;
        end else if (inc) begin
            if (narrow) cnt_q[BYTE_W-1:0] <= lo_b + 1'b1;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (hi_we && !narrow) wbuf_q <= wdata;
            if (lo_re)            rbuf_q <= hi_b;
        end
    end

    assign count   = cnt_q;
    assign hi_view = narrow ? hi_b : rbuf_q;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = TMR_BYTE_W,
    parameter int PRE_W       = TMR_PRE_W,
    parameter int SYNC_STAGES = TMR_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ext_tick_in,
    input  logic              sleep,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    tmr_ctrl_t         ctrl_q;
    logic              flag_q;
    logic              ie_q;
    logic              lo_we, hi_we, ctrl_we, stat_we, lo_re;
    logic              pre_clr;
    logic              active;
    logic              tick_w;
    logic              inc_w;
    logic              wrap_w;
    logic [PRE_W-1:0]  pre_level;
    logic [CNT_W-1:0]  count_w;
    logic [BYTE_W-1:0] hi_view;

    assign lo_we   = reg_we && (reg_addr == ADDR_CNT_LO);
    assign hi_we   = reg_we && (reg_addr == ADDR_CNT_HI);
    assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);
    assign stat_we = reg_we && (reg_addr == ADDR_STAT);
    assign lo_re   = reg_re && (reg_addr == ADDR_CNT_LO);
    assign pre_clr = lo_we || (hi_we && ctrl_q.narrow);
    assign active  = ctrl_q.run && !sleep;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= tmr_ctrl_t'(reg_wdata[7:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wrap_w)                          flag_q <= 1'b1;
            else if (stat_we && !reg_wdata[0])  flag_q <= 1'b0;
            if (stat_we)                         ie_q   <= reg_wdata[1];
        end
    end

    tmr_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_tick_in),
        .use_ext   (ctrl_q.ext_src),
        .fall_edge (ctrl_q.fall_edge),
        .active    (active),
        .tick      (tick_w)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .bypass (ctrl_q.bypass),
        .ratio  (ctrl_q.ratio),
        .clr    (pre_clr),
        .inc    (inc_w),
        .level  (pre_level)
    );

    tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc_w),
        .narrow  (ctrl_q.narrow),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .lo_re   (lo_re),
        .wdata   (reg_wdata),
        .count   (count_w),
        .hi_view (hi_view),
        .wrap    (wrap_w)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_CNT_LO: reg_rdata = count_w[BYTE_W-1:0];
            ADDR_CNT_HI: reg_rdata = hi_view;
            ADDR_CTRL:   reg_rdata = BYTE_W'(ctrl_q);
            default:     reg_rdata = {{(BYTE_W-2){1'b0}}, ie_q, flag_q};
        endcase
    end

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W,
    parameter int PRE_W  = TMR_PRE_W
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_we,
    input logic [1:0]          reg_addr,
    input logic [BYTE_W-1:0]   reg_wdata,
    input logic                sleep,
    input tmr_ctrl_t           ctrl,
    input logic [2*BYTE_W-1:0] count,
    input logic                inc,
    input logic                flag,
    input logic                ie,
    input logic                irq,
    input logic [PRE_W-1:0]    pre_cnt
);
    logic cnt_write;
    assign cnt_write = reg_we && is_count_addr(reg_addr);

    // R2: a stopped timer keeps its count
    p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_write) |=> $stable(count));

    // R2: no advance pulse while stopped
    p_no_inc_off_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !inc);

    // R3: bypass keeps the prescaler at zero
    p_bypass_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl.bypass |=> (pre_cnt == '0));

    // R6: low-byte wrap in 8-bit mode sets the flag
    p_wrap8_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.narrow && inc && (&count[BYTE_W-1:0]) && !cnt_write)
        |=> (flag && count[BYTE_W-1:0] == '0));

    // R7: full-word wrap in 16-bit mode sets the flag
    p_wrap16_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.narrow && inc && (&count) && !cnt_write)
        |=> (flag && count == '0));

    // R8: the flag persists until a clearing status write
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !(reg_we && reg_addr == ADDR_STAT && !reg_wdata[0])) |=> flag);

    // R8: interrupt only with flag and enable
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ie));

    // R12: sleep freezes the count
    p_sleep_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (sleep && !cnt_write) |=> $stable(count));

endmodule

bind prescaled_timer tmr_checker #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sleep     (sleep),
    .ctrl      (ctrl_q),
    .count     (count_w),
    .inc       (inc_w),
    .flag      (flag_q),
    .ie        (ie_q),
    .irq       (irq),
    .pre_cnt   (pre_level)
);

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_tick_in = 1'b0;
    logic       sleep = 1'b0;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    prescaled_timer uut (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ext_tick_in (ext_tick_in),
        .sleep       (sleep),
        .irq         (irq)
    );

    // all tasks start and end on a falling edge; each access spans one rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        vectors++;
        if (irq !== e) begin
            miscompares++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick_in = 1'b1; idle(3);
            ext_tick_in = 1'b0; idle(3);
        end
    endtask

    // monitor: compares each read against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (reg_re) begin
                vectors++;
                if (sb.size() == 0) begin
                    miscompares++;
                    $display("FAIL scoreboard: read with no expectation, actual %h expected none", reg_rdata);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (reg_rdata !== it.exp) begin
                        miscompares++;
                        $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2, 8'h00, "R1"); rd(3, 8'h00, "R1");
        rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1");
        chk_irq(1'b0, "R1");

        // R3 bypass, 8-bit: 10 ticks
        wr(2, 8'h48); wr(0, 8'h10);
        wr(2, 8'hC8); idle(9); wr(2, 8'h48);
        rd(0, 8'h1A, "R3");

        // R4 divide by 4: 23 ticks -> 5
        wr(2, 8'h41); wr(0, 8'h00);
        wr(2, 8'hC1); idle(22); wr(2, 8'h41);
        rd(0, 8'h05, "R4");

        // R4 divide by 256, 16-bit: 600 ticks -> 2
        wr(2, 8'h07); wr(1, 8'h00); wr(0, 8'h00);
        wr(2, 8'h87); idle(599); wr(2, 8'h07);
        rd(0, 8'h02, "R4"); rd(1, 8'h00, "R4");

        // R2 prescaler residue kept across a stop
        wr(2, 8'h00); wr(0, 8'h00);
        wr(2, 8'h80); wr(2, 8'h00);
        idle(10);
        wr(2, 8'h80); wr(2, 8'h00);
        rd(0, 8'h01, "R2");
        idle(10);
        rd(0, 8'h01, "R2");

        // R5 count write clears prescaler, control kept
        wr(2, 8'h01); wr(0, 8'h00);
        wr(2, 8'h81); idle(1); wr(2, 8'h01);
        wr(0, 8'h00);
        rd(2, 8'h01, "R5");
        wr(2, 8'h81); idle(1); wr(2, 8'h01);
        rd(0, 8'h00, "R5");

        // R6 8-bit wrap, high byte untouched
        wr(2, 8'h48); wr(1, 8'h55); wr(0, 8'hFE);
        wr(2, 8'hC8); idle(2); wr(2, 8'h48);
        rd(0, 8'h01, "R6"); rd(1, 8'h55, "R6");
        rd(3, 8'h01, "R6");
        chk_irq(1'b0, "R8");
        idle(5);
        rd(3, 8'h01, "R8");
        wr(3, 8'h03);
        chk_irq(1'b1, "R8");
        rd(3, 8'h03, "R8");
        wr(3, 8'h02);
        chk_irq(1'b0, "R8");
        rd(3, 8'h02, "R8");
        wr(3, 8'h00);

        // R7 16-bit: low carry no flag, full wrap flags
        wr(2, 8'h08); wr(1, 8'h12); wr(0, 8'hFE);
        wr(2, 8'h88); idle(2); wr(2, 8'h08);
        rd(0, 8'h01, "R7"); rd(1, 8'h13, "R7"); rd(3, 8'h00, "R7");
        wr(1, 8'hFF); wr(0, 8'hFE);
        wr(2, 8'h88); idle(2); wr(2, 8'h08);
        rd(0, 8'h01, "R7"); rd(1, 8'h00, "R7"); rd(3, 8'h01, "R7");
        wr(3, 8'h00);

        // R10 buffered high write
        wr(1, 8'hAB);
        rd(0, 8'h01, "R10"); rd(1, 8'h00, "R10");
        wr(0, 8'h22);
        rd(0, 8'h22, "R10"); rd(1, 8'hAB, "R10");

        // R9 high read buffer captured at low read
        wr(1, 8'h77); wr(0, 8'h00);
        rd(1, 8'hAB, "R9");
        rd(0, 8'h00, "R9"); rd(1, 8'h77, "R9");

        // R11 external rising edges, no core-clock counting
        wr(2, 8'h08); wr(1, 8'h00); wr(0, 8'h00);
        wr(2, 8'hA8); idle(10);
        pulses(5); idle(6);
        wr(2, 8'h28);
        rd(0, 8'h05, "R11");
        // R11 falling edges
        wr(0, 8'h00);
        wr(2, 8'hB8);
        pulses(4); idle(6);
        wr(2, 8'h38);
        rd(0, 8'h04, "R11");

        // R12 sleep freezes, no overflow
        wr(2, 8'h08); wr(1, 8'hFF); wr(0, 8'hFE);
        sleep = 1'b1;
        wr(2, 8'h88); idle(10); wr(2, 8'h08);
        sleep = 1'b0;
        rd(0, 8'hFE, "R12"); rd(1, 8'hFF, "R12"); rd(3, 8'h00, "R12");
        chk_irq(1'b0, "R12");

        idle(3);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule